// File: doc/BRIEF.md
# Fixed-Point Edge Slope Engine

This block evaluates one expression of the shape (A ± B) / (C ± D) per command. All four operands and the result are 16-bit two's-complement values with six fraction bits (10.6). One add/subtract unit forms the numerator and a second one forms the denominator. Each unit has its own select line, so a single command can produce an edge slope such as (x2 - x1) / (y2 - y1). A restoring divider then produces the quotient, one bit per clock.

A rasterizer, or the setup logic in front of it, raises `start_i` for one cycle with the operands while `busy_o` is low. It then waits for the one-cycle `done_o` pulse, which comes a fixed number of cycles later. Only one command is in flight at a time. A zero denominator, and any quotient that does not fit in 16 bits, are clamped to the largest value with the right sign instead of wrapping.

The controller has three states. IDLE waits for a command. CALC registers the signs of the two sums and hands their magnitudes to the divider. DIV waits for the divider, then writes the result. The transitions are: IDLE to CALC when start is accepted, CALC to DIV always, DIV to IDLE when the divider finishes, and otherwise each state holds.

Top module: `slope_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `busy_o`, `done_o`, `div_zero_o` and `result_o` are all 0.
- R2: `start_i` sampled high while `busy_o` is low loads the operands, and `busy_o` is high from the next cycle until the cycle in which `done_o` rises.
- R3: The numerator is A+B when `num_sub_i`=0 and A-B when it is 1. The denominator is C+D when `den_sub_i`=0 and C-D when it is 1. Each sum is formed with 17 bits, so it cannot overflow.
- R4: When no clamp applies, the result is (numerator × 64) / denominator, truncated toward zero. This is the 10.6 quotient, and a quotient of magnitude below one LSB gives 0.
- R5: `done_o` is high for exactly one cycle. It rises 25 clock edges after the edge that accepts `start_i` (one load cycle, one setup cycle, 23 divide steps and one write cycle).
- R6: A zero denominator sets `div_zero_o`. The result is then 32767 when the numerator is zero or positive, and -32768 when it is negative.
- R7: A quotient above 32767 gives 32767, and one below -32768 gives -32768. Exactly -32768 is returned unchanged. In both cases `div_zero_o` is 0.
- R8: `start_i` raised while `busy_o` is high is ignored. The command in flight keeps its operands, its result and its timing.
- R9: `result_o` and `div_zero_o` change only in the cycle in which `done_o` is high, and hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, accepted only while idle |
| a_i | input | 16 | Numerator first operand, signed 10.6 |
| b_i | input | 16 | Numerator second operand, signed 10.6 |
| c_i | input | 16 | Denominator first operand, signed 10.6 |
| d_i | input | 16 | Denominator second operand, signed 10.6 |
| num_sub_i | input | 1 | 1 = A-B, 0 = A+B |
| den_sub_i | input | 1 | 1 = C-D, 0 = C+D |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Quotient, signed 10.6, clamped |
| div_zero_o | output | 1 | Last command had a zero denominator |

## Verification
The assertions take for granted that commands only matter while the engine is idle. They therefore demand no particular behaviour from `start_i` or the operand inputs while `busy_o` is high, beyond leaving the loaded operands untouched. The stimulus keeps operands and select lines stable from the start pulse on. Every command after the first waits for `done_o` before it is issued. The one exception is a deliberate second strobe in the middle of a command, which checks that the engine ignores it.

// File: rtl/slope_pkg.sv
package slope_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DIV  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/slope_addsub.sv
module slope_addsub #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    input  logic                sub_i,
    output logic signed [W:0]   s_o
);
    logic signed [W:0] x_ext;
    logic signed [W:0] y_ext;

    always_comb begin
        x_ext = {x_i[W-1], x_i};
        y_ext = {y_i[W-1], y_i};
        s_o   = sub_i ? (x_ext - y_ext) : (x_ext + y_ext);
    end
endmodule

// File: rtl/slope_divider.sv
module slope_divider #(
    parameter int NW = 23,
    parameter int DVW = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic [NW-1:0]  dividend_i,
    input  logic [DVW-1:0] divisor_i,
    output logic [NW-1:0]  quot_o,
    output logic           fin_o
);
    localparam int CW = $clog2(NW);
    localparam logic [CW-1:0] LAST = CW'(NW - 1);

    logic [DVW-1:0] rem_q;
    logic [DVW-1:0] dvs_q;
    logic [NW-1:0]  quo_q;
    logic [CW-1:0]  cnt_q;
    logic           run_q;
    logic [DVW:0]   rem_sh;
    logic           fits;

    always_comb begin
        rem_sh = {rem_q, quo_q[NW-1]};
        fits   = (rem_sh >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            dvs_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_o <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (go_i) begin
                rem_q <= '0;
                dvs_q <= divisor_i;
                quo_q <= dividend_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? DVW'(rem_sh - {1'b0, dvs_q}) : rem_sh[DVW-1:0];
                quo_q <= {quo_q[NW-2:0], fits};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    run_q <= 1'b0;
                    fin_o <= 1'b1;
                end
            end
        end
    end

    assign quot_o = quo_q;

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= LAST)); // R5
    AST_FIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o); // R5
endmodule

// File: rtl/slope_engine.sv
module slope_engine #(
    parameter int W = 16,
    parameter int FRAC = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  logic [W-1:0] d_i,
    input  logic         num_sub_i,
    input  logic         den_sub_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o,
    output logic         div_zero_o
);
    import slope_pkg::*;

    localparam int SW = W + 1;
    localparam int DW = SW + FRAC;
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [DW-1:0] POS_LIM = DW'(POS_MAX);
    localparam logic [DW-1:0] NEG_LIM = DW'(POS_MAX) + 1'b1;

    eng_state_t state_q, state_d;

    logic signed [W-1:0] opx_q [2];
    logic signed [W-1:0] opy_q [2];
    logic                opsub_q [2];
    logic signed [SW-1:0] sum [2];

    logic          neg_n_q, neg_d_q, zero_d_q;
    logic [SW-1:0] mag_n, mag_d;
    logic [DW-1:0] quot;
    logic          div_fin;
    logic          div_go;
    logic          res_neg;
    logic [W-1:0]  res_d;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_alu
            slope_addsub #(.W(W)) u_alu (
                .x_i  (opx_q[g]),
                .y_i  (opy_q[g]),
                .sub_i(opsub_q[g]),
                .s_o  (sum[g])
            );
        end
    endgenerate

    always_comb begin
        mag_n  = sum[0][SW-1] ? SW'(-sum[0]) : SW'(sum[0]);
        mag_d  = sum[1][SW-1] ? SW'(-sum[1]) : SW'(sum[1]);
        div_go = (state_q == ST_CALC);
    end

    slope_divider #(.NW(DW), .DVW(SW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (div_go),
        .dividend_i({mag_n, {FRAC{1'b0}}}),
        .divisor_i (mag_d),
        .quot_o    (quot),
        .fin_o     (div_fin)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_CALC;
            ST_CALC: state_d = ST_DIV;
            ST_DIV:  if (div_fin) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture and sign bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                opx_q[i]   <= '0;
                opy_q[i]   <= '0;
                opsub_q[i] <= 1'b0;
            end
            neg_n_q  <= 1'b0;
            neg_d_q  <= 1'b0;
            zero_d_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                opx_q[0]   <= a_i;
                opy_q[0]   <= b_i;
                opsub_q[0] <= num_sub_i;
                opx_q[1]   <= c_i;
                opy_q[1]   <= d_i;
                opsub_q[1] <= den_sub_i;
            end
            if (state_q == ST_CALC) begin
                neg_n_q  <= sum[0][SW-1];
                neg_d_q  <= sum[1][SW-1];
                zero_d_q <= (sum[1] == '0);
            end
        end
    end

    // result shaping: sign, zero divisor, saturation
    always_comb begin
        res_neg = neg_n_q ^ neg_d_q;
        if (zero_d_q)             res_d = neg_n_q ? NEG_MIN : POS_MAX;
        else if (!res_neg)        res_d = (quot > POS_LIM) ? POS_MAX : quot[W-1:0];
        else if (quot > NEG_LIM)  res_d = NEG_MIN;
        else                      res_d = W'(-quot);
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            result_o   <= '0;
            div_zero_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state_q == ST_DIV && div_fin) begin
                done_o     <= 1'b1;
                result_o   <= res_d;
                div_zero_o <= zero_d_q;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(div_zero_o))); // R9
    AST_DZ_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_zero_o) |-> (result_o == POS_MAX || result_o == NEG_MIN)); // R6
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(opx_q[0]) && $stable(opy_q[0]) && $stable(opx_q[1]) && $stable(opy_q[1]))); // R8
    AST_CALC_TO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CALC) |=> (state_q == ST_DIV)); // R2
endmodule

// File: tb/slope_engine_bench.sv
module slope_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] a_i = '0, b_i = '0, c_i = '0, d_i = '0;
    logic        num_sub_i = 1'b0, den_sub_i = 1'b0;
    logic        busy_o, done_o, div_zero_o;
    logic [15:0] result_o;

    int checks = 0;
    int errors = 0;
    int lat;

    always #2.5 clk = ~clk;

    slope_engine u_slope_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
        .num_sub_i(num_sub_i), .den_sub_i(den_sub_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .div_zero_o(div_zero_o)
    );

    // {a, b, c, d, num_sub, den_sub, expected result, expected div_zero}
    localparam int NV = 14;
    localparam logic [82:0] VECS [NV] = '{
        {16'sd640,  16'sd128,  16'sd192,  16'sd64,  1'b0, 1'b1, 16'sd384,  1'b0}, // R3 R4
        {16'sd100,  16'sd300,  16'sd50,   16'sd30,  1'b1, 1'b0, -16'sd160, 1'b0}, // R3 R4
        {-16'sd64,  -16'sd64,  -16'sd32,  16'sd32,  1'b0, 1'b1, 16'sd128,  1'b0}, // R4
        {16'sd1,    16'sd0,    16'sd3,    16'sd0,   1'b0, 1'b0, 16'sd21,   1'b0}, // R4
        {-16'sd1,   16'sd0,    16'sd3,    16'sd0,   1'b0, 1'b0, -16'sd21,  1'b0}, // R4
        {16'sd32767,16'sd32767,16'sd1,    16'sd0,   1'b0, 1'b0, 16'h7FFF,  1'b0}, // R7
        {16'h8000,  16'sd32767,16'sd1,    16'sd0,   1'b1, 1'b0, 16'h8000,  1'b0}, // R7
        {16'sd64,   16'sd0,    16'sd5,    16'sd5,   1'b0, 1'b1, 16'h7FFF,  1'b1}, // R6
        {-16'sd64,  16'sd0,    16'sd0,    16'sd0,   1'b0, 1'b0, 16'h8000,  1'b1}, // R6
        {16'sd0,    16'sd0,    16'sd0,    16'sd0,   1'b0, 1'b0, 16'h7FFF,  1'b1}, // R6
        {-16'sd512, 16'sd0,    16'sd1,    16'sd0,   1'b0, 1'b0, 16'h8000,  1'b0}, // R7 exact
        {16'sd5,    16'sd5,    16'sd7,    16'sd0,   1'b1, 1'b0, 16'sd0,    1'b0}, // R4
        {16'sd32767,16'h8000,  16'h8000,  16'sd32767,1'b1,1'b0, 16'h8000,  1'b0}, // R7
        {16'sd100,  16'sd0,    16'h8000,  16'sd0,   1'b0, 1'b0, 16'sd0,    1'b0}  // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drives one command and returns the number of negedges until done is seen
    task automatic run_cmd(input logic [82:0] v, output int n);
        @(negedge clk);
        {a_i, b_i, c_i, d_i, num_sub_i, den_sub_i} = v[82:17];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        while (!done_o && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        check("R1 busy", 32'(busy_o), 0);
        check("R1 result", 32'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", 32'(done_o), 0);
        check("R1 div_zero", 32'(div_zero_o), 0);

        for (int i = 0; i < NV; i++) begin
            run_cmd(VECS[i], n);
            check("R4/R6/R7 result", 32'(result_o), 32'(VECS[i][16:1]));
            check("R6 div_zero", 32'(div_zero_o), 32'(VECS[i][0]));
            check("R5 latency", 32'(n), 26);
            check("R2 busy low at done", 32'(busy_o), 0);
        end

        // R2: busy rises the cycle after start is accepted
        @(negedge clk);
        {a_i, b_i, c_i, d_i, num_sub_i, den_sub_i} = VECS[0][82:17];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after start", 32'(busy_o), 1);
        // R8: second strobe mid-command with other operands
        repeat (4) @(negedge clk);
        {a_i, b_i, c_i, d_i, num_sub_i, den_sub_i} = VECS[1][82:17];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 6;
        while (!done_o && n < 200) begin
            @(negedge clk);
            n++;
        end
        check("R8 latency unchanged", 32'(n), 26);
        check("R8 result of first command", 32'(result_o), 32'(16'sd384));

        // R5 / R9: pulse lasts one cycle, outputs hold afterwards
        held = result_o;
        @(negedge clk);
        check("R5 done single cycle", 32'(done_o), 0);
        check("R8 no second command", 32'(busy_o), 0);
        repeat (10) @(negedge clk);
        check("R9 result held", 32'(result_o), 32'(held));
        check("R9 div_zero held", 32'(div_zero_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule